// File: doc/BRIEF.md
# Universal Bus Transceiver Data Path

This block moves 17-bit words in both directions between an A side and a B side of a chip, without inverting them. Each direction has its own set of four controls: an active-low clock enable, a latch enable, a transfer clock and an active-low output enable. Together these controls select one of four behaviours for that direction. The output can follow the input directly (transparent). It can freeze the input when the latch enable drops (latched). It can capture the input on a rising transfer-clock edge (clocked). Or it can do so only while the clock enable is low (clock-enabled). Each bit has one storage element, and that element serves as both the latch and the flip-flop.

The transfer clocks and the latch enables are plain level inputs. The block samples them with its own core clock `clk` and finds transfer-clock edges by comparing each sample with the previous one. Every tri-state output is modelled as a data bus plus a drive-enable output. The block also carries a buffered clock path. The A-to-B transfer clock is sent out as a clock output. The level seen on that clock output pad is passed back as a returned clock. Each leg of this path is gated by the output enable of its own direction. A flag output reports when both directions are asked to drive at once.

Top module: `ubt_xcvr`

## Requirements
- R1: Both data paths are 17 bits wide and noninverting. After reset every storage bit is 0, so an output whose latch enable is low reads 0.
- R2: When a direction's output enable input is 1, that direction's drive-enable output is 0, whatever the other controls are. When the output enable input is 0, the drive-enable output is 1.
- R3: While a direction's latch enable is 1, its data output equals its data input in the same cycle, whatever the clock enable and transfer clock are.
- R4: With clock enable 0 and latch enable 0, a rising transfer-clock edge stores the input. The edge is the first core cycle in which the transfer clock is sampled 1 after being sampled 0. The input stored is the one present in that cycle, and the output shows it from the next core cycle.
- R5: With clock enable 0 and latch enable 0, the output keeps its stored value while the transfer clock stays at 1 or stays at 0, even if the input changes.
- R6: When the latch enable falls from 1 to 0 and no edge occurs, the stored value is the input from the last core cycle in which the latch enable was 1.
- R7: With clock enable 1 and latch enable 0, transfer-clock edges have no effect and the output holds its value. The clock enable acts on all 17 bits together.
- R8: The B-to-A direction follows R2 to R7 using its own four controls, and the A-to-B controls have no effect on it.
- R9: The clock output always equals the A-to-B transfer clock. Its drive enable is 1 exactly when the A-to-B output enable is 0.
- R10: The returned clock equals the level on the clock-output pad. Its drive enable is 1 exactly when the B-to-A output enable is 0.
- R11: The contention flag is 1 exactly when both output enables are 0.
- R12: If a rising edge with clock enable 0 falls in the same core cycle as the latch enable's fall, the edge decides. The stored value is the input of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all controls |
| rstN | input | 1 | Active-low synchronous reset |
| aIn | input | 17 | Data arriving at the A side |
| aOut | output | 17 | Data driven onto the A side (B-to-A path) |
| aOe | output | 1 | Drive enable for aOut |
| bIn | input | 17 | Data arriving at the B side |
| bOut | output | 17 | Data driven onto the B side (A-to-B path) |
| bOe | output | 1 | Drive enable for bOut |
| abClkEnN | input | 1 | A-to-B clock enable, active low |
| abLatchEn | input | 1 | A-to-B latch enable, 1 = transparent |
| abClk | input | 1 | A-to-B transfer clock |
| abOutEnN | input | 1 | A-to-B output enable, active low |
| baClkEnN | input | 1 | B-to-A clock enable, active low |
| baLatchEn | input | 1 | B-to-A latch enable, 1 = transparent |
| baClk | input | 1 | B-to-A transfer clock |
| baOutEnN | input | 1 | B-to-A output enable, active low |
| clkOut | output | 1 | Buffered copy of abClk |
| clkOutOe | output | 1 | Drive enable for clkOut |
| clkLoopIn | input | 1 | Level on the clock-output pad |
| clkRet | output | 1 | Returned clock |
| clkRetOe | output | 1 | Drive enable for clkRet |
| bothDriveFlag | output | 1 | Both directions enabled to drive |

## Verification
The storage element of each bit takes two kinds of load: tracking while the latch is open, and capture on a transfer-clock edge. These two meet when the latch enable falls in the same core cycle that the transfer clock is first seen high. The bench provokes this by first loading one word through the open latch. On a single falling clock edge of the bench it then drops the latch enable, raises the transfer clock and presents a second word. A cycle later it checks that the output shows the second word, as R12 requires, and not the first word that R6 alone would give.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int unsigned DataW = 17;

  // Strobes from a direction's control to its data path
  typedef struct packed {
    logic passThru;  // output follows input combinationally
    logic load;      // storage takes the input at the next core edge
    logic drive;     // output drive enable
  } dirStrobeT;
endpackage

// File: rtl/ubt_dir_ctrl.sv
module ubt_dir_ctrl
  import ubt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clkEnN,
  input  logic      latchEn,
  input  logic      dirClk,
  input  logic      outEnN,
  output dirStrobeT strobe
);
  logic clkPrev;
  logic clkRise;

  // Reset value 1 so that a clock held high through reset is not seen as an edge
  always_ff @(posedge clk) begin
    if (!rstN) clkPrev <= 1'b1;
    else       clkPrev <= dirClk;
  end

  assign clkRise = dirClk & ~clkPrev;

  always_comb begin
    strobe.passThru = latchEn;
    strobe.load     = latchEn | (clkRise & ~clkEnN);
    strobe.drive    = ~outEnN;
  end
endmodule

// File: rtl/ubt_dir_path.sv
module ubt_dir_path
  import ubt_pkg::*;
#(
  parameter int unsigned W = DataW
) (
  input  logic         clk,
  input  logic         rstN,
  input  dirStrobeT    strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         doutOe
);
  logic [W-1:0] store;

  always_ff @(posedge clk) begin
    if (!rstN)            store <= '0;
    else if (strobe.load) store <= din;
  end

  assign dout   = strobe.passThru ? din : store;
  assign doutOe = strobe.drive;
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int unsigned W = DataW
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic         aOe,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bOut,
  output logic         bOe,
  input  logic         abClkEnN,
  input  logic         abLatchEn,
  input  logic         abClk,
  input  logic         abOutEnN,
  input  logic         baClkEnN,
  input  logic         baLatchEn,
  input  logic         baClk,
  input  logic         baOutEnN,
  output logic         clkOut,
  output logic         clkOutOe,
  input  logic         clkLoopIn,
  output logic         clkRet,
  output logic         clkRetOe,
  output logic         bothDriveFlag
);
  dirStrobeT abStrobe;
  dirStrobeT baStrobe;

  ubt_dir_ctrl u_abCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(abClkEnN), .latchEn(abLatchEn),
    .dirClk(abClk), .outEnN(abOutEnN), .strobe(abStrobe)
  );
  ubt_dir_path #(.W(W)) u_abPath (
    .clk(clk), .rstN(rstN), .strobe(abStrobe), .din(aIn),
    .dout(bOut), .doutOe(bOe)
  );

  ubt_dir_ctrl u_baCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(baClkEnN), .latchEn(baLatchEn),
    .dirClk(baClk), .outEnN(baOutEnN), .strobe(baStrobe)
  );
  ubt_dir_path #(.W(W)) u_baPath (
    .clk(clk), .rstN(rstN), .strobe(baStrobe), .din(bIn),
    .dout(aOut), .doutOe(aOe)
  );

  // Buffered clock path
  assign clkOut        = abClk;
  assign clkOutOe      = ~abOutEnN;
  assign clkRet        = clkLoopIn;
  assign clkRetOe      = ~baOutEnN;
  assign bothDriveFlag = ~abOutEnN & ~baOutEnN;

  // R2
  ab_isolate_chk: assert property (@(posedge clk) disable iff (!rstN)
    abOutEnN |-> !bOe);
  // R3
  ab_transparent_chk: assert property (@(posedge clk) disable iff (!rstN)
    abLatchEn |-> (bOut == aIn));
  // R4
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!abClkEnN && !abLatchEn && abClk && !$past(abClk)) |=>
      (abLatchEn || bOut == $past(aIn)));
  // R7
  ab_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abClkEnN && !abLatchEn) |=> (abLatchEn || $stable(bOut)));
  // R8
  ba_transparent_chk: assert property (@(posedge clk) disable iff (!rstN)
    baLatchEn |-> (aOut == bIn));
  // R11
  contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    bothDriveFlag |-> (aOe && bOe));
endmodule

// File: tb/ubt_xcvr_tb.sv
`timescale 1ns/1ps
module ubt_xcvr_tb;
  localparam int W = 17;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut;
  logic aOe, bOe, clkOut, clkOutOe, clkRet, clkRetOe, bothDriveFlag;
  logic abClkEnN = 1'b1, abLatchEn = 1'b0, abClk = 1'b0, abOutEnN = 1'b1;
  logic baClkEnN = 1'b1, baLatchEn = 1'b0, baClk = 1'b0, baOutEnN = 1'b1;
  logic clkLoopIn = 1'b0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ubt_xcvr u_dut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .abClkEnN(abClkEnN), .abLatchEn(abLatchEn), .abClk(abClk), .abOutEnN(abOutEnN),
    .baClkEnN(baClkEnN), .baLatchEn(baLatchEn), .baClk(baClk), .baOutEnN(baOutEnN),
    .clkOut(clkOut), .clkOutOe(clkOutOe), .clkLoopIn(clkLoopIn),
    .clkRet(clkRet), .clkRetOe(clkRetOe), .bothDriveFlag(bothDriveFlag)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic test_reset();  // R1
    chk("R1 reset bOut", bOut, '0);
    chk("R1 reset aOut", aOut, '0);
  endtask

  task automatic test_isolation();  // R2
    abOutEnN = 1'b1; abLatchEn = 1'b1; abClkEnN = 1'b0; #1;
    chk("R2 bOe off", {16'd0, bOe}, 17'd0);
    abOutEnN = 1'b0; #1;
    chk("R2 bOe on", {16'd0, bOe}, 17'd1);
    cyc(1);
  endtask

  task automatic test_transparent();  // R3, R1 noninverting
    abLatchEn = 1'b1; abClkEnN = 1'b1; aIn = 17'h15A5A; #1;
    chk("R3 follow", bOut, 17'h15A5A);
    abClk = 1'b1; aIn = 17'h0A5A5; #1;
    chk("R1 noninverting", bOut, 17'h0A5A5);
    cyc(1); abClk = 1'b0; cyc(1);
  endtask

  task automatic test_latch_close();  // R6
    abLatchEn = 1'b1; aIn = 17'h01234; cyc(1);
    abLatchEn = 1'b0; aIn = 17'h1FFFF; cyc(2);
    chk("R6 latched", bOut, 17'h01234);
  endtask

  task automatic test_edge_capture();  // R4, R5
    abClkEnN = 1'b0; abClk = 1'b0; cyc(1);
    abClk = 1'b1; aIn = 17'h1C3C3; #1;
    chk("R4 before edge", bOut, 17'h01234);
    cyc(1);
    chk("R4 captured", bOut, 17'h1C3C3);
    aIn = 17'h00001; cyc(3);
    chk("R5 clock high hold", bOut, 17'h1C3C3);
    abClk = 1'b0; aIn = 17'h00002; cyc(3);
    chk("R5 clock low hold", bOut, 17'h1C3C3);
  endtask

  task automatic test_inhibit();  // R7
    abClkEnN = 1'b1; aIn = 17'h0F0F0;
    abClk = 1'b1; cyc(2); abClk = 1'b0; cyc(1); abClk = 1'b1; cyc(2);
    chk("R7 inhibit", bOut, 17'h1C3C3);
    abClk = 1'b0; cyc(1);
  endtask

  task automatic test_coincide();  // R12
    abClkEnN = 1'b0; abLatchEn = 1'b1; aIn = 17'h00AAA; cyc(1);
    abLatchEn = 1'b0; abClk = 1'b1; aIn = 17'h15555; cyc(1);
    aIn = 17'h00000; cyc(1);
    chk("R12 edge wins", bOut, 17'h15555);
    abClk = 1'b0; abClkEnN = 1'b1; cyc(1);
  endtask

  task automatic test_ba();  // R8
    baOutEnN = 1'b0; #1;
    chk("R8 aOe on", {16'd0, aOe}, 17'd1);
    baLatchEn = 1'b1; bIn = 17'h13579; #1;
    chk("R8 follow", aOut, 17'h13579);
    cyc(1); baLatchEn = 1'b0; bIn = 17'h00000; cyc(1);
    baClkEnN = 1'b0; baClk = 1'b1; bIn = 17'h02468; cyc(1);
    chk("R8 capture", aOut, 17'h02468);
    baClk = 1'b0; abClk = 1'b1; abClkEnN = 1'b0; abLatchEn = 1'b1; bIn = 17'h1111F; cyc(2);
    chk("R8 ab controls no effect", aOut, 17'h02468);
    abClk = 1'b0; abLatchEn = 1'b0; abClkEnN = 1'b1; cyc(1);
  endtask

  task automatic test_clock_path();  // R9, R10, R11
    chk("R11 both on", {16'd0, bothDriveFlag}, 17'd1);
    abClk = 1'b1; clkLoopIn = 1'b1; #1;
    chk("R9 clkOut high", {16'd0, clkOut}, 17'd1);
    chk("R9 clkOutOe", {16'd0, clkOutOe}, 17'd1);
    chk("R10 clkRet high", {16'd0, clkRet}, 17'd1);
    chk("R10 clkRetOe", {16'd0, clkRetOe}, 17'd1);
    abClk = 1'b0; clkLoopIn = 1'b0; abOutEnN = 1'b1; #1;
    chk("R9 clkOut low", {16'd0, clkOut}, 17'd0);
    chk("R9 clkOutOe off", {16'd0, clkOutOe}, 17'd0);
    chk("R11 one off", {16'd0, bothDriveFlag}, 17'd0);
    baOutEnN = 1'b1; #1;
    chk("R10 clkRetOe off", {16'd0, clkRetOe}, 17'd0);
    cyc(1);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    test_reset();
    test_isolation();
    test_transparent();
    test_latch_close();
    test_edge_capture();
    test_inhibit();
    test_coincide();
    test_ba();
    test_clock_path();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule